// File: doc/BRIEF.md
# Block Lock-Bit Command Sequencer

This block is the command-decoding front end of a flash-style memory that guards its per-block write-protection bits. A host writes a lock-setup opcode with a block address on the bus, then a confirm opcode aimed at the same block. Only that two-write handshake starts a timed lock-bit write. The physical cell write is modelled as a fixed-length busy interval. When the interval ends, the block's bit in a small lock register is set. Once set, that lock bit refuses later program and erase requests to the block.

The block keeps a status byte. It holds a ready flag, an erase/sequence error flag, a program/lock error flag and a protect-violation flag. After any command that starts work or can fail, reads are steered to the status byte instead of array data. They stay there until the host asks for array reads again. A write-protect supply-valid input that is low at confirm time blocks the change and records a violation. A suspended device and a running operation both refuse a new setup.

Top module: `lockbit_seq`

## Requirements
- R1: After reset, reads return array data (`rd_data` equals `arr_rdata`), every lock bit is 0 and the device is ready.
- R2: The status byte has ready at bit 7, erase/sequence error at bit 5, program/lock error at bit 4, protect violation at bit 3, and zeros elsewhere. A setup opcode (60h) on block B followed by a confirm opcode (01h) on block B, with `wp_ok` high, makes bit 7 read 0 for exactly BUSY_CYC cycles. Lock bit B is set when that interval ends.
- R3: A setup, program (40h), erase (20h) or read-status (70h) write switches reads to the status byte. Reads stay there until a read-array write (FFh).
- R4: If the write after a setup is not the confirm opcode, or names a different block, bits 5 and 4 are set and no lock bit changes.
- R5: A confirm received while `wp_ok` is low sets bits 4 and 3, starts no busy interval and leaves the lock bits unchanged.
- R6: A setup written while an operation is running or while `suspended` is high is refused. It sets bits 5 and 4, and the confirm that follows it is ignored.
- R7: A program to a locked block sets bit 4 and an erase to a locked block sets bit 5, and neither starts a busy interval. The same requests to an unlocked block run for BUSY_CYC cycles.
- R8: A clear-status write (50h) in idle clears bits 5, 4 and 3 and leaves bit 7 unchanged.
- R9: In idle, an unrecognised opcode such as a stray confirm has no effect. During a busy interval, every write other than setup is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_blk | input | BLK_W | Block-select bits of the write address |
| wr_data | input | 8 | Command byte |
| wp_ok | input | 1 | Write-protect supply valid (low means lockout) |
| suspended | input | 1 | Device is in a suspended state |
| arr_rdata | input | 8 | Array read data from the memory core |
| rd_data | output | 8 | Read data: status byte or array data |
| lock_q | output | 2**BLK_W | Per-block lock bits |

## Verification
The setup/confirm handshake is tried in several forms. The matched pair on two different blocks shows which bit is committed. A wrong second byte and a mismatched block tell the two rejection causes apart from success. A clear-status opcode used as the second byte shows that any non-confirm is rejected, not only unknown codes. A lowered write-protect input at confirm separates the violation flag from the sequence error. Program and erase to locked and unlocked blocks show the gating and which error bit each sets. Setup written during a busy interval and while suspended shows that refusal also discards the later confirm. Counting the not-ready cycles pins the busy length.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    typedef enum logic [2:0] {
        C_NONE, C_SETUP, C_CONFIRM, C_CLEAR, C_RDSTAT, C_RDARR, C_PROG, C_ERASE
    } cmd_e;

    localparam logic [7:0] OP_CLEAR  = 8'h50;
    localparam logic [7:0] OP_RDSTAT = 8'h70;
    localparam logic [7:0] OP_RDARR  = 8'hFF;
    localparam logic [7:0] OP_PROG   = 8'h40;
    localparam logic [7:0] OP_ERASE  = 8'h20;
endpackage

// File: rtl/lbs_decode.sv
module lbs_decode
    import lbs_pkg::*;
#(
    parameter logic [7:0] OP_SETUP   = 8'h60,
    parameter logic [7:0] OP_CONFIRM = 8'h01
) (
    input  logic [7:0] op,
    output cmd_e       cmd
);
    always_comb begin
        if      (op == OP_SETUP)   cmd = C_SETUP;
        else if (op == OP_CONFIRM) cmd = C_CONFIRM;
        else if (op == OP_CLEAR)   cmd = C_CLEAR;
        else if (op == OP_RDSTAT)  cmd = C_RDSTAT;
        else if (op == OP_RDARR)   cmd = C_RDARR;
        else if (op == OP_PROG)    cmd = C_PROG;
        else if (op == OP_ERASE)   cmd = C_ERASE;
        else                       cmd = C_NONE;
    end
endmodule

// File: rtl/lbs_timer.sv
module lbs_timer #(
    parameter int BUSY_CYC = 6,
    localparam int CW = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (busy)       cnt_d = cnt_q - CW'(1);
        else if (start) cnt_d = CW'(BUSY_CYC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lbs_rdmux.sv
module lbs_rdmux (
    input  logic       stat_sel,
    input  logic [7:0] sr,
    input  logic [7:0] arr,
    output logic [7:0] dout
);
    assign dout = stat_sel ? sr : arr;
endmodule

// File: rtl/lockbit_seq.sv
module lockbit_seq
    import lbs_pkg::*;
#(
    parameter int         BLK_W      = 3,
    parameter int         BUSY_CYC   = 6,
    parameter logic [7:0] OP_SETUP   = 8'h60,
    parameter logic [7:0] OP_CONFIRM = 8'h01,
    localparam int        NBLK       = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic [7:0]       wr_data,
    input  logic             wp_ok,
    input  logic             suspended,
    input  logic [7:0]       arr_rdata,
    output logic [7:0]       rd_data,
    output logic [NBLK-1:0]  lock_q
);
    typedef struct packed {
        logic             rd_stat;
        logic             pending;
        logic [BLK_W-1:0] pend_blk;
        logic             op_lock;
        logic [BLK_W-1:0] op_blk;
        logic             err5;
        logic             err4;
        logic             pv3;
        logic [NBLK-1:0]  lock;
    } st_t;

    st_t  st_d, st_q;
    cmd_e cmd;
    logic go, busy_w, done_w;
    logic [7:0] sr_w;

    lbs_decode #(.OP_SETUP(OP_SETUP), .OP_CONFIRM(OP_CONFIRM)) u_dec (
        .op(wr_data), .cmd(cmd)
    );

    lbs_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(go), .busy(busy_w), .done(done_w)
    );

    assign sr_w = {~busy_w, 1'b0, st_q.err5, st_q.err4, st_q.pv3, 3'b000};

    lbs_rdmux u_mux (
        .stat_sel(st_q.rd_stat), .sr(sr_w), .arr(arr_rdata), .dout(rd_data)
    );

    assign lock_q = st_q.lock;

    always_comb begin
        st_d = st_q;
        go   = 1'b0;
        if (done_w && st_q.op_lock) st_d.lock[st_q.op_blk] = 1'b1;
        if (wr_en) begin
            if (st_q.pending) begin
                st_d.pending = 1'b0;
                if (cmd != C_CONFIRM || wr_blk != st_q.pend_blk || suspended) begin
                    st_d.err5 = 1'b1;
                    st_d.err4 = 1'b1;
                end else if (!wp_ok) begin
                    st_d.err4 = 1'b1;
                    st_d.pv3  = 1'b1;
                end else begin
                    go            = 1'b1;
                    st_d.op_lock  = 1'b1;
                    st_d.op_blk   = wr_blk;
                end
            end else if (busy_w) begin
                if (cmd == C_SETUP) begin
                    st_d.err5    = 1'b1;
                    st_d.err4    = 1'b1;
                    st_d.rd_stat = 1'b1;
                end
            end else begin
                case (cmd)
                    C_SETUP: begin
                        st_d.rd_stat = 1'b1;
                        if (suspended) begin
                            st_d.err5 = 1'b1;
                            st_d.err4 = 1'b1;
                        end else begin
                            st_d.pending  = 1'b1;
                            st_d.pend_blk = wr_blk;
                        end
                    end
                    C_CLEAR: begin
                        st_d.err5 = 1'b0;
                        st_d.err4 = 1'b0;
                        st_d.pv3  = 1'b0;
                    end
                    C_RDSTAT: st_d.rd_stat = 1'b1;
                    C_RDARR:  st_d.rd_stat = 1'b0;
                    C_PROG, C_ERASE: begin
                        st_d.rd_stat = 1'b1;
                        if (st_q.lock[wr_blk]) begin
                            if (cmd == C_PROG) st_d.err4 = 1'b1;
                            else               st_d.err5 = 1'b1;
                        end else begin
                            go           = 1'b1;
                            st_d.op_lock = 1'b0;
                            st_d.op_blk  = wr_blk;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
    parameter int         NBLK       = 8,
    parameter logic [7:0] OP_CONFIRM = 8'h01,
    parameter logic [7:0] OP_CLR     = 8'h50
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [7:0]      wr_data,
    input logic            wp_ok,
    input logic            busy,
    input logic            pending,
    input logic [7:0]      sr,
    input logic [NBLK-1:0] lock_q
);
    p_lock_only_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

    p_lock_stable_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(lock_q));

    p_bad_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wr_en && wr_data != OP_CONFIRM) |=> (sr[5] && sr[4]));

    p_wp_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wr_en && !wp_ok) |=> (sr[4] && !busy));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == OP_CLR && !pending && !busy) |=> (sr[5:3] == 3'b000));

    p_busy_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));
endmodule

bind lockbit_seq lbs_checker #(.NBLK(NBLK), .OP_CONFIRM(OP_CONFIRM), .OP_CLR(lbs_pkg::OP_CLEAR)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wp_ok(wp_ok),
    .busy(busy_w), .pending(st_q.pending), .sr(sr_w), .lock_q(lock_q)
);

// File: tb/tb_lockbit_seq.sv
module tb_lockbit_seq;
    localparam int BLK_W = 3;
    localparam int NBLK  = 1 << BLK_W;
    localparam int CYC   = 6;
    localparam int NV    = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [BLK_W-1:0] wr_blk = '0;
    logic [7:0] wr_data = '0;
    logic wp_ok = 1'b1;
    logic suspended = 1'b0;
    logic [7:0] arr_rdata = 8'h5A;
    logic [7:0] rd_data;
    logic [NBLK-1:0] lock_q;

    int nchk = 0;
    int nbad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    lockbit_seq #(.BLK_W(BLK_W), .BUSY_CYC(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_blk(wr_blk), .wr_data(wr_data),
        .wp_ok(wp_ok), .suspended(suspended), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .lock_q(lock_q)
    );

    // {opcode, block, wp_ok, expected read after settling, expected lock bits}
    localparam logic [27:0] VEC [NV] = '{
        {8'h60, 3'd2, 1'b1, 8'h80, 8'h00},  // R3 setup -> status
        {8'h01, 3'd2, 1'b1, 8'h80, 8'h04},  // R2 lock block 2
        {8'h60, 3'd5, 1'b1, 8'h80, 8'h04},
        {8'h01, 3'd5, 1'b1, 8'h80, 8'h24},  // R2 lock block 5
        {8'h60, 3'd1, 1'b1, 8'h80, 8'h24},
        {8'hD0, 3'd1, 1'b1, 8'hB0, 8'h24},  // R4 wrong second byte
        {8'h50, 3'd0, 1'b1, 8'h80, 8'h24},  // R8 clear
        {8'h60, 3'd3, 1'b1, 8'h80, 8'h24},
        {8'h01, 3'd4, 1'b1, 8'hB0, 8'h24},  // R4 other block
        {8'h50, 3'd0, 1'b1, 8'h80, 8'h24},
        {8'h60, 3'd6, 1'b1, 8'h80, 8'h24},
        {8'h01, 3'd6, 1'b0, 8'h98, 8'h24},  // R5 lockout
        {8'h50, 3'd0, 1'b1, 8'h80, 8'h24},  // R8 clears bit 3
        {8'h40, 3'd2, 1'b1, 8'h90, 8'h24},  // R7 program locked
        {8'h50, 3'd0, 1'b1, 8'h80, 8'h24},
        {8'h20, 3'd5, 1'b1, 8'hA0, 8'h24},  // R7 erase locked
        {8'h50, 3'd0, 1'b1, 8'h80, 8'h24},
        {8'h40, 3'd0, 1'b1, 8'h80, 8'h24},  // R7 program unlocked
        {8'h20, 3'd7, 1'b1, 8'h80, 8'h24},  // R7 erase unlocked
        {8'hFF, 3'd0, 1'b1, 8'h5A, 8'h24},  // R3 read array
        {8'h70, 3'd0, 1'b1, 8'h80, 8'h24},  // R3 read status
        {8'h01, 3'd3, 1'b1, 8'h80, 8'h24},  // R9 stray confirm
        {8'h60, 3'd3, 1'b1, 8'h80, 8'h24},
        {8'h50, 3'd3, 1'b1, 8'hB0, 8'h24},  // R4 clear opcode as second byte
        {8'h50, 3'd0, 1'b1, 8'h80, 8'h24},
        {8'hFF, 3'd0, 1'b1, 8'h5A, 8'h24},
        {8'h60, 3'd4, 1'b1, 8'h80, 8'h24},  // R3 setup leaves array mode
        {8'h01, 3'd4, 1'b1, 8'h80, 8'h34}   // R2 lock block 4
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [BLK_W-1:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_blk = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (CYC + 2) @(negedge clk);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        int nbusy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 array read", rd_data, 8'h5A);
        chk("R1 locks", 8'(lock_q), 8'h00);

        for (int i = 0; i < NV; i++) begin
            wp_ok = VEC[i][16];
            wr(VEC[i][27:20], VEC[i][19:17]);
            wp_ok = 1'b1;
            settle();
            chk($sformatf("vector %0d read", i), rd_data, VEC[i][15:8]);
            chk($sformatf("vector %0d lock", i), 8'(lock_q), VEC[i][7:0]);
        end

        // R2: busy length and commit at end
        wr(8'h60, 3'd0);
        wr(8'h01, 3'd0);
        nbusy = 0;
        for (int i = 0; i < 40; i++) begin
            if (!rd_data[7]) nbusy++;
            if (i == 1) chk("R2 lock not set while busy", 8'(lock_q), 8'h34);
            @(negedge clk);
        end
        chk("R2 busy cycles", 8'(nbusy), 8'(CYC));
        chk("R2 lock block 0", 8'(lock_q), 8'h35);

        // R6/R9: setup during busy refused, later confirm ignored
        wr(8'h40, 3'd7);
        wr(8'h60, 3'd3);
        wr(8'h50, 3'd0);          // R9 ignored while busy
        settle();
        chk("R6 setup while busy", rd_data, 8'hB0);
        wr(8'h01, 3'd3);
        settle();
        chk("R6 confirm after refused setup", rd_data, 8'hB0);
        chk("R6 lock unchanged", 8'(lock_q), 8'h35);
        wr(8'h50, 3'd0);
        settle();
        chk("R8 clear", rd_data, 8'h80);

        // R6: suspended refuses setup
        suspended = 1'b1;
        wr(8'h60, 3'd3);
        wr(8'h01, 3'd3);
        settle();
        chk("R6 suspended status", rd_data, 8'hB0);
        chk("R6 suspended lock", 8'(lock_q), 8'h35);
        suspended = 1'b0;

        // R1: reset returns to array mode and clears locks
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 array read after reset", rd_data, 8'h5A);
        chk("R1 locks after reset", 8'(lock_q), 8'h00);
        wr(8'h70, 3'd0);
        chk("R1 ready after reset", rd_data, 8'h80);

        summary();
        $finish;
    end
endmodule